// File: doc/BRIEF.md
# Indirect Table Access Port

This block gives software a two-register window onto a set of internal lookup tables. An address register selects the table and the entry and holds an auto-advance flag. A data register then reads or writes the chosen entry. Each table has a fixed power-of-two size. The entry index is cut down to that size before use, so out-of-range indices alias onto valid entries.

When the auto-advance flag is set, every data access steps the stored index to the next entry, wrapping within the table. Software can therefore stream a whole table through the data register without rewriting the address. Some table selects are decoded but have no storage behind them; these read as zero. Select codes that are not defined raise an error pulse and leave the address register untouched.

Two tables tell neighbouring logic when they change. The interrupt-vector table keeps only its routing fields and reports each update. The wide-window table raises a re-evaluation strobe that carries the index of the entry written. The block only stores entries and sequences access to them; what the entries mean is left to other logic.

Top module: `itp_top`

## Requirements
- R1: After reset every table entry reads zero, the address register reads zero, and rd_valid, sel_err, vec_upd and win_upd are low.
- R2: A write to the address register (acc_is_data=0) stores the auto-advance flag from bit 63, the table select from bits 51:48 and the index from bits 9:0. A read of it returns those fields in the same positions, with every other bit zero.
- R3: A data access uses the index field ANDed with the mask of the selected table. The masks are: 3 for select 13; 7 for selects 0, 1 and 5; 15 for select 11; 31 for selects 2 and 3; 63 for selects 4, 9 and 10; 255 for selects 6, 7 and 12; 511 for select 8.
- R4: Selects 0, 1, 8, 11, 12 and 13 are backed by storage. A data write stores acc_wdata at the masked index, and a later data read of that entry returns it.
- R5: Selects 2, 3, 4, 5, 6, 7, 9 and 10 have no storage. Data reads of them return zero, and data writes to them change no backed table.
- R6: Selects 14 and 15 are undefined. A data access to one of them pulses sel_err for one cycle, a read returns zero, a write is dropped, and the address register is not changed, even with auto-advance set.
- R7: When auto-advance is set, each data access to a defined select, read or write, first uses the current masked index. It then stores ((masked index + 1) AND mask) into the index field. Without the flag, the index field is left unchanged.
- R8: A data write to select 1 stores only bits 19:0 of acc_wdata, namely server 15:8, priority 7:0 and node 19:16. All other bits are stored as zero.
- R9: A data write to select 1 pulses vec_upd for one cycle. The pulse carries the masked index on vec_upd_idx, server bits 15:10 (the server field without its two low link bits) on vec_upd_server, and bits 7:0 on vec_upd_prio.
- R10: A data write to select 11 pulses win_upd for one cycle, with the pre-advance masked index on win_upd_idx. No other access pulses win_upd or vec_upd.
- R11: Read data appears on rd_data, with rd_valid high, in the cycle after the read is accepted. An address-register write takes effect for the very next data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_is_data | input | 1 | 1 = data register, 0 = address register |
| acc_wdata | input | 64 | Write value |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read value |
| sel_err | output | 1 | Undefined-select access pulse |
| vec_upd | output | 1 | Vector-table entry updated |
| vec_upd_idx | output | 3 | Updated vector entry index |
| vec_upd_server | output | 6 | Server value without link bits |
| vec_upd_prio | output | 8 | Priority of updated vector entry |
| win_upd | output | 1 | Window-table entry re-evaluation strobe |
| win_upd_idx | output | 4 | Index of the written window entry |

## Verification
The tight case is a data access that uses an entry and, in the same cycle, advances the index. A write to the window or vector table must report the pre-advance index while the address register already moves on. A read must return the entry at the old index. Directed sequences provoke this at the wrap point of the smallest tables. Randomised runs mix auto-advance reads and writes across all sixteen selects, and the bench model predicts both the reported index and the readback of the address register afterwards.

// File: rtl/itp_pkg.sv
package itp_pkg;

  localparam int SEL_W      = 4;
  localparam int IDX_W      = 10;
  localparam int NUM_BACKED = 6;
  localparam int SLOT_W     = 3;

  localparam logic [SEL_W-1:0] SEL_LINK  = 4'd0;
  localparam logic [SEL_W-1:0] SEL_IVEC  = 4'd1;
  localparam logic [SEL_W-1:0] SEL_XLAT  = 4'd8;
  localparam logic [SEL_W-1:0] SEL_WIN64 = 4'd11;
  localparam logic [SEL_W-1:0] SEL_MAP32 = 4'd12;
  localparam logic [SEL_W-1:0] SEL_EVEC  = 4'd13;
  localparam logic [SEL_W-1:0] SEL_LAST  = 4'd13;

  // fields kept by a vector-table write
  localparam int IVEC_KEEP_W = 20;

  function automatic logic [IDX_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
    case (s)
      4'd0, 4'd1, 4'd5:   sel_mask = 10'd7;
      4'd2, 4'd3:         sel_mask = 10'd31;
      4'd4, 4'd9, 4'd10:  sel_mask = 10'd63;
      4'd6, 4'd7, 4'd12:  sel_mask = 10'd255;
      4'd8:               sel_mask = 10'd511;
      4'd11:              sel_mask = 10'd15;
      4'd13:              sel_mask = 10'd3;
      default:            sel_mask = 10'd0;
    endcase
  endfunction

  function automatic logic sel_defined(input logic [SEL_W-1:0] s);
    sel_defined = (s <= SEL_LAST);
  endfunction

  function automatic int backed_sel(input int k);
    case (k)
      0: backed_sel = 0;
      1: backed_sel = 1;
      2: backed_sel = 8;
      3: backed_sel = 11;
      4: backed_sel = 12;
      default: backed_sel = 13;
    endcase
  endfunction

  function automatic int slot_depth(input int k);
    slot_depth = int'(sel_mask(SEL_W'(backed_sel(k)))) + 1;
  endfunction

  function automatic logic sel_backed(input logic [SEL_W-1:0] s);
    sel_backed = (s == SEL_LINK) || (s == SEL_IVEC) || (s == SEL_XLAT) ||
                 (s == SEL_WIN64) || (s == SEL_MAP32) || (s == SEL_EVEC);
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [SEL_W-1:0] s);
    case (s)
      SEL_IVEC:  slot_of = 3'd1;
      SEL_XLAT:  slot_of = 3'd2;
      SEL_WIN64: slot_of = 3'd3;
      SEL_MAP32: slot_of = 3'd4;
      SEL_EVEC:  slot_of = 3'd5;
      default:   slot_of = 3'd0;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i,
                                                 input logic [IDX_W-1:0] m);
    next_idx = ((i & m) + 10'd1) & m;
  endfunction

endpackage

// File: rtl/itp_addr_reg.sv
module itp_addr_reg
  import itp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             ld_ainc,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic             data_acc,
  output logic             ainc,
  output logic [SEL_W-1:0] sel,
  output logic [IDX_W-1:0] idx_raw,
  output logic [IDX_W-1:0] eff_idx,
  output logic             defined
);

  logic [IDX_W-1:0] mask;
  logic             advance;

  assign mask    = sel_mask(sel);
  assign defined = sel_defined(sel);
  assign eff_idx = idx_raw & mask;
  assign advance = data_acc && defined && ainc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ainc    <= 1'b0;
      sel     <= '0;
      idx_raw <= '0;
    end else if (ld) begin
      ainc    <= ld_ainc;
      sel     <= ld_sel;
      idx_raw <= ld_idx;
    end else if (advance) begin
      idx_raw <= next_idx(idx_raw, mask);
    end
  end

  AST_AUTOINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ld && defined && ainc) |=>
      (idx_raw == (($past(eff_idx) + 10'd1) & $past(mask)))); // R7

  AST_NOINC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ld && !ainc) |=> (idx_raw == $past(idx_raw))); // R7

  AST_BADSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ld && !defined) |=>
      ($stable(idx_raw) && $stable(sel) && $stable(ainc))); // R6

endmodule

// File: rtl/itp_table.sv
module itp_table #(
  parameter int DEPTH  = 8,
  parameter int AW     = 3,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/itp_notify.sv
module itp_notify
  import itp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vec_we,
  input  logic       win_we,
  input  logic [3:0] idx,
  input  logic [5:0] srv_hi,
  input  logic [7:0] prio,
  output logic       vec_upd,
  output logic [2:0] vec_upd_idx,
  output logic [5:0] vec_upd_server,
  output logic [7:0] vec_upd_prio,
  output logic       win_upd,
  output logic [3:0] win_upd_idx
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_upd        <= 1'b0;
      vec_upd_idx    <= '0;
      vec_upd_server <= '0;
      vec_upd_prio   <= '0;
      win_upd        <= 1'b0;
      win_upd_idx    <= '0;
    end else begin
      vec_upd <= vec_we;
      win_upd <= win_we;
      if (vec_we) begin
        vec_upd_idx    <= idx[2:0];
        vec_upd_server <= srv_hi;
        vec_upd_prio   <= prio;
      end
      if (win_we) win_upd_idx <= idx;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_upd && win_upd)); // R10

  AST_WIN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    win_upd |-> $past(win_we)); // R10

  AST_VEC_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    vec_upd |-> $past(vec_we)); // R9

endmodule

// File: rtl/itp_top.sv
module itp_top
  import itp_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SEL_LSB  = 48,
  parameter int AINC_BIT = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_is_data,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sel_err,
  output logic              vec_upd,
  output logic [2:0]        vec_upd_idx,
  output logic [5:0]        vec_upd_server,
  output logic [7:0]        vec_upd_prio,
  output logic              win_upd,
  output logic [3:0]        win_upd_idx
);

  localparam logic [DATA_W-1:0] IVEC_KEEP = DATA_W'((64'd1 << IVEC_KEEP_W) - 64'd1);

  logic             data_acc, addr_wr, data_wr;
  logic             ainc, defined, backed;
  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] idx_raw, eff_idx;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] tbl_wdata, addr_view, rd_next;
  logic [DATA_W-1:0] rd_arr [NUM_BACKED];

  assign data_acc  = acc_valid && acc_is_data;
  assign addr_wr   = acc_valid && !acc_is_data && acc_write;
  assign data_wr   = data_acc && acc_write;
  assign backed    = sel_backed(sel);
  assign slot      = slot_of(sel);
  assign tbl_wdata = (sel == SEL_IVEC) ? (acc_wdata & IVEC_KEEP) : acc_wdata;

  itp_addr_reg u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (addr_wr),
    .ld_ainc  (acc_wdata[AINC_BIT]),
    .ld_sel   (acc_wdata[SEL_LSB +: SEL_W]),
    .ld_idx   (acc_wdata[IDX_W-1:0]),
    .data_acc (data_acc),
    .ainc     (ainc),
    .sel      (sel),
    .idx_raw  (idx_raw),
    .eff_idx  (eff_idx),
    .defined  (defined)
  );

  always_comb begin
    addr_view = '0;
    addr_view[AINC_BIT]          = ainc;
    addr_view[SEL_LSB +: SEL_W]  = sel;
    addr_view[IDX_W-1:0]         = idx_raw;
  end

  for (genvar k = 0; k < NUM_BACKED; k++) begin : g_tbl
    localparam int DEP = slot_depth(k);
    localparam int AW  = $clog2(DEP);
    localparam logic [SEL_W-1:0] CODE = SEL_W'(backed_sel(k));
    logic we_k;
    assign we_k = data_wr && (sel == CODE);
    itp_table #(.DEPTH(DEP), .AW(AW), .DATA_W(DATA_W)) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_k),
      .idx   (eff_idx[AW-1:0]),
      .wdata (tbl_wdata),
      .rdata (rd_arr[k])
    );
  end

  always_comb begin
    if (!acc_is_data)  rd_next = addr_view;
    else if (!backed)  rd_next = '0;
    else               rd_next = rd_arr[slot];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      sel_err  <= 1'b0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      sel_err  <= data_acc && !defined;
      if (acc_valid && !acc_write) rd_data <= rd_next;
    end
  end

  itp_notify u_notify (
    .clk            (clk),
    .rst_n          (rst_n),
    .vec_we         (data_wr && (sel == SEL_IVEC)),
    .win_we         (data_wr && (sel == SEL_WIN64)),
    .idx            (eff_idx[3:0]),
    .srv_hi         (acc_wdata[15:10]),
    .prio           (acc_wdata[7:0]),
    .vec_upd        (vec_upd),
    .vec_upd_idx    (vec_upd_idx),
    .vec_upd_server (vec_upd_server),
    .vec_upd_prio   (vec_upd_prio),
    .win_upd        (win_upd),
    .win_upd_idx    (win_upd_idx)
  );

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid); // R11

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> ($past(data_acc) && !$past(defined))); // R6

  AST_UNBACKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !acc_write && !backed) |=> (rd_data == '0)); // R5

  AST_IVEC_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !acc_write && (sel == SEL_IVEC)) |=>
      ((rd_data & ~IVEC_KEEP) == '0)); // R8

endmodule

// File: tb/test_itp_top.sv
module test_itp_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_is_data = 1'b0;
  logic [63:0] acc_wdata = '0;
  logic        rd_valid, sel_err, vec_upd, win_upd;
  logic [63:0] rd_data;
  logic [2:0]  vec_upd_idx;
  logic [5:0]  vec_upd_server;
  logic [7:0]  vec_upd_prio;
  logic [3:0]  win_upd_idx;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] m [16][512];
  logic        m_ainc;
  logic [3:0]  m_sel;
  logic [9:0]  m_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  itp_top i_itp_top (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_is_data(acc_is_data), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .sel_err(sel_err), .vec_upd(vec_upd),
    .vec_upd_idx(vec_upd_idx), .vec_upd_server(vec_upd_server),
    .vec_upd_prio(vec_upd_prio), .win_upd(win_upd), .win_upd_idx(win_upd_idx)
  );

  function automatic logic [9:0] bmask(input logic [3:0] s);
    case (s)
      13: return 3;
      0, 1, 5: return 7;
      11: return 15;
      2, 3: return 31;
      4, 9, 10: return 63;
      6, 7, 12: return 255;
      8: return 511;
      default: return 0;
    endcase
  endfunction

  function automatic bit bbacked(input logic [3:0] s);
    return s inside {0, 1, 8, 11, 12, 13};
  endfunction

  function automatic logic [63:0] addr_word(input logic a, input logic [3:0] s,
                                            input logic [9:0] i);
    return {a, 11'b0, s, 38'b0, i};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one access, checked against the model one edge later
  task automatic acc(input bit w, input bit d, input logic [63:0] v);
    logic [9:0]  ei;
    logic [63:0] exp_rd;
    bit def, e_vec, e_win;
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_is_data = d; acc_wdata = v;
    def   = (m_sel <= 13);
    ei    = m_idx & bmask(m_sel);
    e_vec = w && d && m_sel == 1;
    e_win = w && d && m_sel == 11;
    if (!d) exp_rd = addr_word(m_ainc, m_sel, m_idx);
    else if (!bbacked(m_sel)) exp_rd = 0;
    else exp_rd = m[m_sel][ei];
    @(posedge clk); #1;
    chk(rd_valid == !w, "R11", 64'(rd_valid), 64'(!w));
    if (!w) begin
      if (!d) chk(rd_data == exp_rd, "R2", rd_data, exp_rd);
      else if (!def) chk(rd_data == 0, "R6", rd_data, 0);
      else if (!bbacked(m_sel)) chk(rd_data == 0, "R5", rd_data, 0);
      else chk(rd_data == exp_rd, "R4", rd_data, exp_rd);
    end
    chk(sel_err == (d && !def), "R6", 64'(sel_err), 64'(d && !def));
    chk(vec_upd == e_vec, "R9", 64'(vec_upd), 64'(e_vec));
    chk(win_upd == e_win, "R10", 64'(win_upd), 64'(e_win));
    if (e_vec) begin
      chk(vec_upd_idx == ei[2:0], "R9", 64'(vec_upd_idx), 64'(ei[2:0]));
      chk(vec_upd_server == v[15:10], "R9", 64'(vec_upd_server), 64'(v[15:10]));
      chk(vec_upd_prio == v[7:0], "R9", 64'(vec_upd_prio), 64'(v[7:0]));
    end
    if (e_win) chk(win_upd_idx == ei[3:0], "R10", 64'(win_upd_idx), 64'(ei[3:0]));
    // model update
    if (!d) begin
      if (w) begin m_ainc = v[63]; m_sel = v[51:48]; m_idx = v[9:0]; end
    end else if (def) begin
      if (w && bbacked(m_sel))
        m[m_sel][ei] = (m_sel == 1) ? (v & 64'hF_FFFF) : v;
      if (m_ainc) m_idx = (ei + 10'd1) & bmask(m_sel);
    end
  endtask

  task automatic set_addr(input logic a, input logic [3:0] s, input logic [9:0] i);
    acc(1, 0, addr_word(a, s, i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] rv;
    void'($urandom(32'd7331));
    for (int s = 0; s < 16; s++) for (int i = 0; i < 512; i++) m[s][i] = 0;
    m_ainc = 0; m_sel = 0; m_idx = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!rd_valid && !sel_err && !vec_upd && !win_upd, "R1", 0, 0);
    @(negedge clk); rst_n = 1;
    // R1: address register and tables read zero after reset
    acc(0, 0, 0);
    for (int s = 0; s < 14; s++) begin
      if (bbacked(4'(s))) begin set_addr(0, 4'(s), 10'd2); acc(0, 1, 0); end
    end
    // R3: index aliasing in the four-entry table
    set_addr(0, 13, 10'd9);
    acc(1, 1, 64'hDEAD_BEEF_0000_0001);
    set_addr(0, 13, 10'd1);
    acc(0, 1, 0);
    // R7 + R10: window wrap, strobe carries pre-advance index
    set_addr(1, 11, 10'd14);
    acc(1, 1, 64'h1111);
    acc(1, 1, 64'h2222);
    acc(1, 1, 64'h3333);
    acc(0, 0, 0);
    // R11: readback right after address write, auto-advance read
    set_addr(1, 11, 10'd15);
    acc(0, 1, 0);
    acc(0, 1, 0);
    acc(0, 0, 0);
    // R8 + R9: vector entry keeps only its fields
    set_addr(0, 1, 10'd5);
    acc(1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    acc(0, 1, 0);
    // R5: unbacked select drops writes, reads zero
    set_addr(1, 6, 10'd255);
    acc(1, 1, 64'hABCD);
    set_addr(0, 6, 10'd255);
    acc(0, 1, 0);
    acc(0, 0, 0);
    // R6: undefined select leaves address untouched
    set_addr(1, 14, 10'd3);
    acc(0, 1, 0);
    acc(1, 1, 64'h55);
    acc(0, 0, 0);
    set_addr(1, 15, 10'd1023);
    acc(0, 1, 0);
    acc(0, 0, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      rv = {$urandom, $urandom};
      if (op < 2) begin
        set_addr(1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
                 10'($urandom));
      end else if (op < 3) acc(0, 0, 0);
      else if (op < 6) acc(0, 1, 0);
      else acc(1, 1, rv);
    end
    @(negedge clk);
    acc_valid = 0;
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule